// File: doc/BRIEF.md
# Critical-Chunk-First Line Mover

This block sits between a wide line store and a narrow data path. A line is four chunks of 256 bits. Chunk k occupies line bits [k*256 +: 256]. On the read side, the block accepts a whole line together with a 2-bit critical chunk index k. It then sends the line as four beats in the order k, (k+1) mod 4, (k+2) mod 4 and (k+3) mod 4. Each beat carries its own chunk index and flags that mark the first and the last beat.

On the write side, the block accepts 256-bit beats that are each tagged with a chunk index, in any order. A 4-bit received mask records which chunks have arrived. Once all four bits are set, the assembled line is offered to the store as one wide commit. A beat whose index was already received replaces the stored chunk and raises a one-cycle error pulse. Both sides use valid/ready handshakes.

The read side is a two-state machine. RD_IDLE moves to RD_SEND when a request is accepted. RD_SEND moves back to RD_IDLE when the beat flagged last is accepted. The write side is also a two-state machine. WR_GATHER moves to WR_COMMIT when the beat that completes the mask is accepted. WR_COMMIT moves back to WR_GATHER, with the mask cleared, when the commit is accepted. Reset is synchronous and active low.

Top module: `cxf_top`

## Requirements
- R1: After reset, the read request ready is 1, the read beat valid is 0, the write beat ready is 1, the commit valid is 0 and the error pulse is 0.
- R2: The first beat after an accepted read request carries chunk index k equal to the requested critical index, has the first flag set, and holds line bits [k*256 +: 256].
- R3: Each later read beat carries the previous index plus one, modulo 4, together with that chunk's data.
- R4: The first flag is set only on beat 1 of 4 and the last flag only on beat 4 of 4. Exactly four beats are sent for each request.
- R5: While a read beat is valid and not accepted, its data, index and flags hold stable.
- R6: While beats of a read are outstanding, the read request ready is 0, so no new read is accepted.
- R7: The commit valid stays 0 until beats for all four chunk indices have been accepted. The committed line then holds, at [k*256 +: 256], the last data accepted for index k.
- R8: A write beat whose index was already received overwrites that chunk. It raises the error pulse for exactly the one cycle after it is accepted.
- R9: While a commit is pending, the write beat ready is 0, any beat offered is ignored, and the commit line holds stable until the commit is accepted.
- R10: After a commit is accepted, the received mask is empty. The next line needs four fresh beats before it commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request can be taken |
| rd_req_line | input | 1024 | Full line to send |
| rd_req_crit | input | 2 | Critical chunk index |
| rd_beat_valid | output | 1 | Read beat present |
| rd_beat_ready | input | 1 | Read beat consumed |
| rd_beat_data | output | 256 | Read beat data |
| rd_beat_idx | output | 2 | Chunk index of read beat |
| rd_beat_first | output | 1 | Beat is the first of four |
| rd_beat_last | output | 1 | Beat is the last of four |
| wr_beat_valid | input | 1 | Write beat offered |
| wr_beat_ready | output | 1 | Write beat can be taken |
| wr_beat_data | input | 256 | Write beat data |
| wr_beat_idx | input | 2 | Chunk index of write beat |
| wr_dup_err | output | 1 | One-cycle pulse after a duplicate index |
| wr_commit_valid | output | 1 | Full line ready for the store |
| wr_commit_ready | input | 1 | Store takes the line |
| wr_commit_line | output | 1024 | Assembled line |

## Verification
The first read beat appears in the cycle after the request handshake edge. Each later beat appears in the cycle after the previous beat's handshake. The commit valid rises one cycle after the edge that accepts the fourth distinct chunk. The error pulse is high only in the cycle after the duplicate beat's edge. The bench changes inputs on the falling edge and samples outputs just after it, so each check looks at the cycle in which the result is due. It sweeps every critical index, with and without stalls, and all 24 write orders.

// File: rtl/cxf_pkg.sv
package cxf_pkg;
    typedef enum logic {RD_IDLE, RD_SEND} rd_state_t;
    typedef enum logic {WR_GATHER, WR_COMMIT} wr_state_t;
endpackage

// File: rtl/cxf_rd_stream.sv
module cxf_rd_stream
    import cxf_pkg::*;
#(
    parameter int CHUNK_W = 256,
    parameter int NCHUNK  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [CHUNK_W*NCHUNK-1:0] req_line,
    input  logic [$clog2(NCHUNK)-1:0] req_crit,
    output logic                      beat_valid,
    input  logic                      beat_ready,
    output logic [CHUNK_W-1:0]        beat_data,
    output logic [$clog2(NCHUNK)-1:0] beat_idx,
    output logic                      beat_first,
    output logic                      beat_last
);
    localparam int IDX_W  = $clog2(NCHUNK);
    localparam int LINE_W = CHUNK_W * NCHUNK;

    rd_state_t          state_q, state_d;
    logic [LINE_W-1:0]  line_q;
    logic [IDX_W-1:0]   cur_q;
    logic [IDX_W-1:0]   cnt_q;
    logic [CHUNK_W-1:0] chunk [NCHUNK];

    for (genvar g = 0; g < NCHUNK; g++) begin : g_slice
        assign chunk[g] = line_q[g*CHUNK_W +: CHUNK_W];
    end

    wire take_req  = req_valid && req_ready;
    wire take_beat = beat_valid && beat_ready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (take_req) state_d = RD_SEND;
            RD_SEND: if (take_beat && beat_last) state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RD_IDLE;
            cur_q   <= '0;
            cnt_q   <= '0;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_req) begin
                line_q <= req_line;
                cur_q  <= req_crit;
                cnt_q  <= '0;
            end else if (take_beat) begin
                cur_q <= cur_q + 1'b1;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        req_ready  = 1'b0;
        beat_valid = 1'b0;
        unique case (state_q)
            RD_IDLE: req_ready  = 1'b1;
            RD_SEND: beat_valid = 1'b1;
        endcase
        beat_data  = chunk[cur_q];
        beat_idx   = cur_q;
        beat_first = beat_valid && (cnt_q == '0);
        beat_last  = beat_valid && (cnt_q == IDX_W'(NCHUNK - 1));
    end

    // R2
    crit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |=> (beat_valid && beat_first && beat_idx == $past(req_crit)));
    // R3
    wrap_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_beat && !beat_last) |=> (beat_valid && beat_idx == IDX_W'($past(beat_idx) + 1'b1)));
    // R4
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_beat && beat_last) |=> !beat_valid);
    // R5
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_data) && $stable(beat_idx)));
    // R6
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> !req_ready);
endmodule

// File: rtl/cxf_wr_gather.sv
module cxf_wr_gather
    import cxf_pkg::*;
#(
    parameter int CHUNK_W = 256,
    parameter int NCHUNK  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      beat_valid,
    output logic                      beat_ready,
    input  logic [CHUNK_W-1:0]        beat_data,
    input  logic [$clog2(NCHUNK)-1:0] beat_idx,
    output logic                      dup_err,
    output logic                      commit_valid,
    input  logic                      commit_ready,
    output logic [CHUNK_W*NCHUNK-1:0] commit_line
);
    localparam int IDX_W = $clog2(NCHUNK);

    wr_state_t          state_q, state_d;
    logic [NCHUNK-1:0]  mask_q;
    logic [CHUNK_W-1:0] store_q [NCHUNK];
    logic               dup_q;

    wire               take_beat   = beat_valid && beat_ready;
    wire               take_commit = commit_valid && commit_ready;
    wire [NCHUNK-1:0]  hit         = NCHUNK'(1) << beat_idx;
    wire               now_full    = &(mask_q | hit);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_GATHER: if (take_beat && now_full) state_d = WR_COMMIT;
            WR_COMMIT: if (take_commit) state_d = WR_GATHER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_GATHER;
            mask_q  <= '0;
            dup_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            dup_q   <= take_beat && ((mask_q & hit) != '0);
            if (take_commit)    mask_q <= '0;
            else if (take_beat) mask_q <= mask_q | hit;
        end
    end

    for (genvar g = 0; g < NCHUNK; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (take_beat && beat_idx == IDX_W'(g)) store_q[g] <= beat_data;
        end
        assign commit_line[g*CHUNK_W +: CHUNK_W] = store_q[g];
    end

    always_comb begin
        beat_ready   = 1'b0;
        commit_valid = 1'b0;
        unique case (state_q)
            WR_GATHER: beat_ready   = 1'b1;
            WR_COMMIT: commit_valid = 1'b1;
        endcase
        dup_err = dup_q;
    end

    // R7
    commit_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(commit_valid) |-> $past(take_beat));
    // R9
    commit_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> !beat_ready);
    // R9
    commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !commit_ready) |=> (commit_valid && $stable(commit_line)));
    // R10
    commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_commit |=> !commit_valid);
endmodule

// File: rtl/cxf_top.sv
module cxf_top #(
    parameter int CHUNK_W = 256,
    parameter int NCHUNK  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_req_valid,
    output logic                      rd_req_ready,
    input  logic [CHUNK_W*NCHUNK-1:0] rd_req_line,
    input  logic [$clog2(NCHUNK)-1:0] rd_req_crit,
    output logic                      rd_beat_valid,
    input  logic                      rd_beat_ready,
    output logic [CHUNK_W-1:0]        rd_beat_data,
    output logic [$clog2(NCHUNK)-1:0] rd_beat_idx,
    output logic                      rd_beat_first,
    output logic                      rd_beat_last,
    input  logic                      wr_beat_valid,
    output logic                      wr_beat_ready,
    input  logic [CHUNK_W-1:0]        wr_beat_data,
    input  logic [$clog2(NCHUNK)-1:0] wr_beat_idx,
    output logic                      wr_dup_err,
    output logic                      wr_commit_valid,
    input  logic                      wr_commit_ready,
    output logic [CHUNK_W*NCHUNK-1:0] wr_commit_line
);
    cxf_rd_stream #(.CHUNK_W(CHUNK_W), .NCHUNK(NCHUNK)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (rd_req_valid),
        .req_ready  (rd_req_ready),
        .req_line   (rd_req_line),
        .req_crit   (rd_req_crit),
        .beat_valid (rd_beat_valid),
        .beat_ready (rd_beat_ready),
        .beat_data  (rd_beat_data),
        .beat_idx   (rd_beat_idx),
        .beat_first (rd_beat_first),
        .beat_last  (rd_beat_last)
    );

    cxf_wr_gather #(.CHUNK_W(CHUNK_W), .NCHUNK(NCHUNK)) u_wr (
        .clk          (clk),
        .rst_n        (rst_n),
        .beat_valid   (wr_beat_valid),
        .beat_ready   (wr_beat_ready),
        .beat_data    (wr_beat_data),
        .beat_idx     (wr_beat_idx),
        .dup_err      (wr_dup_err),
        .commit_valid (wr_commit_valid),
        .commit_ready (wr_commit_ready),
        .commit_line  (wr_commit_line)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(!rst_n) |-> (rd_req_ready && !rd_beat_valid && wr_beat_ready && !wr_commit_valid));
endmodule

// File: tb/tb_cxf_top.sv
module tb_cxf_top;
    localparam int CW = 256;
    localparam int NC = 4;
    localparam int LW = CW * NC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req_valid = 1'b0;
    logic          rd_req_ready;
    logic [LW-1:0] rd_req_line = '0;
    logic [1:0]    rd_req_crit = '0;
    logic          rd_beat_valid;
    logic          rd_beat_ready = 1'b0;
    logic [CW-1:0] rd_beat_data;
    logic [1:0]    rd_beat_idx;
    logic          rd_beat_first, rd_beat_last;
    logic          wr_beat_valid = 1'b0;
    logic          wr_beat_ready;
    logic [CW-1:0] wr_beat_data = '0;
    logic [1:0]    wr_beat_idx = '0;
    logic          wr_dup_err;
    logic          wr_commit_valid;
    logic          wr_commit_ready = 1'b0;
    logic [LW-1:0] wr_commit_line;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    cxf_top dut (.*);

    function automatic logic [CW-1:0] mk_chunk(int seed, int k);
        return {8{seed[15:0], 8'(k), 8'hC3}};
    endfunction

    function automatic logic [LW-1:0] mk_line(int seed);
        logic [LW-1:0] l;
        for (int k = 0; k < NC; k++) l[k*CW +: CW] = mk_chunk(seed, k);
        return l;
    endfunction

    task automatic chk(bit ok, string req, logic [LW-1:0] act, logic [LW-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_read(int seed, int crit, bit stall);
        logic [LW-1:0] l = mk_line(seed);
        @(negedge clk);
        rd_req_valid = 1'b1; rd_req_line = l; rd_req_crit = 2'(crit);
        #1 chk(rd_req_ready == 1'b1, "R6 idle ready", LW'(rd_req_ready), LW'(1));
        @(posedge clk);
        @(negedge clk);
        rd_req_valid = 1'b0;
        for (int b = 0; b < NC; b++) begin
            int k = (crit + b) % NC;
            if (stall) begin
                rd_beat_ready = 1'b0;
                @(posedge clk);
                @(negedge clk);
                #1 chk(rd_beat_valid && rd_beat_idx == 2'(k), "R5 stalled beat held",
                       LW'(rd_beat_idx), LW'(k));
            end
            rd_beat_ready = 1'b1;
            #1;
            chk(rd_beat_valid == 1'b1, "R4 beat present", LW'(rd_beat_valid), LW'(1));
            chk(rd_beat_idx == 2'(k), (b == 0) ? "R2 crit idx" : "R3 wrap idx",
                LW'(rd_beat_idx), LW'(k));
            chk(rd_beat_data == mk_chunk(seed, k), "R3 beat data",
                LW'(rd_beat_data), LW'(mk_chunk(seed, k)));
            chk(rd_beat_first == (b == 0) && rd_beat_last == (b == NC - 1), "R4 flags",
                LW'({rd_beat_first, rd_beat_last}), LW'({b == 0, b == NC - 1}));
            chk(rd_req_ready == 1'b0, "R6 busy", LW'(rd_req_ready), LW'(0));
            @(posedge clk);
            @(negedge clk);
        end
        rd_beat_ready = 1'b0;
        #1 chk(!rd_beat_valid && rd_req_ready, "R4 four beats only",
               LW'({rd_beat_valid, rd_req_ready}), LW'(2'b01));
    endtask

    task automatic send_beat(int k, logic [CW-1:0] d);
        @(negedge clk);
        wr_beat_valid = 1'b1; wr_beat_idx = 2'(k); wr_beat_data = d;
        #1 chk(wr_beat_ready == 1'b1, "R10 beat taken", LW'(wr_beat_ready), LW'(1));
        @(posedge clk);
        @(negedge clk);
        wr_beat_valid = 1'b0;
    endtask

    task automatic finish_commit(logic [LW-1:0] exp);
        #1;
        chk(wr_commit_valid == 1'b1, "R7 commit up", LW'(wr_commit_valid), LW'(1));
        chk(wr_commit_line == exp, "R7 commit line", wr_commit_line, exp);
        wr_beat_valid = 1'b1; wr_beat_idx = 2'd1; wr_beat_data = '1;
        #1 chk(wr_beat_ready == 1'b0, "R9 blocked", LW'(wr_beat_ready), LW'(0));
        @(posedge clk);
        @(negedge clk);
        wr_beat_valid = 1'b0;
        #1 chk(wr_commit_valid && wr_commit_line == exp, "R9 line held", wr_commit_line, exp);
        wr_commit_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_commit_ready = 1'b0;
        #1 chk(!wr_commit_valid && wr_beat_ready, "R10 back to gather",
               LW'({wr_commit_valid, wr_beat_ready}), LW'(2'b01));
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk(rd_req_ready && !rd_beat_valid && wr_beat_ready && !wr_commit_valid && !wr_dup_err,
               "R1 reset state", LW'({rd_req_ready, rd_beat_valid, wr_beat_ready,
               wr_commit_valid, wr_dup_err}), LW'(5'b10100));

        for (int c = 0; c < NC; c++) begin
            do_read(c + 1, c, 1'b0);
            do_read(c + 40, c, 1'b1);
        end

        for (int a = 0; a < NC; a++)
            for (int b = 0; b < NC; b++)
                for (int c = 0; c < NC; c++)
                    for (int d = 0; d < NC; d++) begin
                        int seed = 100 + a * 64 + b * 16 + c * 4 + d;
                        if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
                        send_beat(a, mk_chunk(seed, a));
                        send_beat(b, mk_chunk(seed, b));
                        send_beat(c, mk_chunk(seed, c));
                        #1 chk(!wr_commit_valid, "R10 three beats no commit",
                               LW'(wr_commit_valid), LW'(0));
                        send_beat(d, mk_chunk(seed, d));
                        finish_commit(mk_line(seed));
                    end

        begin
            logic [LW-1:0] exp = mk_line(7);
            exp[2*CW +: CW] = mk_chunk(9, 2);
            send_beat(2, mk_chunk(7, 2));
            #1 chk(!wr_dup_err, "R8 no error first", LW'(wr_dup_err), LW'(0));
            send_beat(2, mk_chunk(9, 2));
            #1 chk(wr_dup_err == 1'b1, "R8 dup pulse", LW'(wr_dup_err), LW'(1));
            send_beat(0, mk_chunk(7, 0));
            #1 chk(!wr_dup_err && !wr_commit_valid, "R8 pulse one cycle",
                   LW'({wr_dup_err, wr_commit_valid}), LW'(0));
            send_beat(3, mk_chunk(7, 3));
            send_beat(1, mk_chunk(7, 1));
            finish_commit(exp);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule